// File: doc/BRIEF.md
# Indexed Register Display Timing Slave

This block sits on a byte-wide display control bus as a slave. It keeps a small bank of 16-bit control registers reached by index, plus a 16-bit-wide table memory that holds the line table, the frame table and the cursor glyph. A master opens a transfer by raising chip select, then moves one byte per strobe. A three-bit register-select code picks the port: the index port, the indexed register data port, or the table memory data port.

A three-byte write to the index port sets the index and writes a 16-bit value in one go. A one-byte write to the index port only moves the index, and the value is then read or written through the register data port, high byte first. The memory data port moves one 16-bit word per two bytes, at the address held in indexed register 0x07, and steps that address after each word. The eleven control bits held at index 0x10 leave the block on a port of their own for the video timing logic.

Top module: `disp_index_slave`

## Requirements
- R1: `ack` is high in the cycle after each clock edge where `cs` and `strobe` were both high, and low in every other cycle.
- R2: On select code 0, a write of three bytes takes byte 1 as the index and bytes 2 and 3 as the high and low halves of a value written to that index. Further bytes in the same chip-select period are ignored.
- R3: On select code 0, a one-byte write only loads the index. A two-byte read on select code 1 then returns the indexed register, high byte first. A read of the first byte on select code 0 returns the current index.
- R4: On select code 1, a two-byte write (high byte, then low byte) writes the register at the current index.
- R5: Only indices 0x00 to 0x10 and 0x20 exist. Reading any other index returns zero, and writing one changes nothing.
- R6: Index 0x10 keeps only its low 11 bits, and its bits 15..11 read as zero. Those 11 bits drive `ctrl` from the clock edge of the write onward. The bit order is: bit 0 vertical interrupt enable, 1 display enable, 2 video enable, 3 display-ID enable, 4 cursor enable, 5 genlock sync enable, 6 interlace enable, 7 cursor display enable, 8 cross-hair cursor enable, 9 64-pixel glyph select, 10 genlock select.
- R7: On select code 3, two bytes (high, then low) read or write the memory word at the address in index 0x07. After the second byte that address goes up by one.
- R8: Index 0x07 counts through all 16 bits. The memory uses only its low `RAM_AW` bits, so address 0x800 reaches word 0 when `RAM_AW` is 11. The line table starts at word 0x000, the frame table at 0x400 and the glyph at 0x500.
- R9: Select codes 2 and 4 to 7 are acknowledged, read as zero and change no state.
- R10: After reset, all registers are zero and `dout`, `ack` and `ctrl` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select. Dropping it restarts the byte count |
| strobe | input | 1 | One byte moves in each cycle where it is high |
| rd | input | 1 | 1 = read byte, 0 = write byte |
| sel | input | 3 | Register-select code |
| din | input | 8 | Write byte |
| dout | output | 8 | Read byte, valid while `ack` is high |
| ack | output | 1 | Byte acknowledge |
| ctrl | output | 11 | Control bits from index 0x10 |

## Verification
The bench builds the block with the default `RAM_AW` of 11, so the memory has 2048 words. At that size the line, frame and glyph regions all fit, and the address register can be pushed past 0x7FF to show the wrap to word 0 while the register itself keeps counting. A behavioural model holds registers and memory in integer arrays. Every clock it checks the acknowledge and the control bits against that model, and every read byte is checked as well.

// File: rtl/dts_pkg.sv
package dts_pkg;
    localparam int IDX_W   = 8;
    localparam int WORD_W  = 16;
    localparam int CTRL_W  = 11;
    localparam int N_SLOTS = 18;

    localparam logic [IDX_W-1:0] IDX_RAMADDR  = 8'h07;
    localparam logic [IDX_W-1:0] IDX_CTRL     = 8'h10;
    localparam logic [IDX_W-1:0] IDX_LAST_LOW = 8'h10;
    localparam logic [IDX_W-1:0] IDX_HIGH     = 8'h20;

    localparam logic [4:0] SLOT_ADDR = 5'd7;
    localparam logic [4:0] SLOT_CTRL = 5'd16;
    localparam logic [4:0] SLOT_HIGH = 5'd17;

    localparam logic [2:0] SEL_INDEX   = 3'd0;
    localparam logic [2:0] SEL_REGDATA = 3'd1;
    localparam logic [2:0] SEL_RAMDATA = 3'd3;

    // control bit positions (consumers decode these)
    localparam int CB_VINT_EN    = 0;
    localparam int CB_DISP_EN    = 1;
    localparam int CB_VIDEO_EN   = 2;
    localparam int CB_DID_EN     = 3;
    localparam int CB_CURS_EN    = 4;
    localparam int CB_GSYNC_EN   = 5;
    localparam int CB_ILACE_EN   = 6;
    localparam int CB_CDISP_EN   = 7;
    localparam int CB_XHAIR_EN   = 8;
    localparam int CB_GLYPH64    = 9;
    localparam int CB_GLOCK_SEL  = 10;

    typedef struct packed {
        logic [1:0]       cnt;
        logic [IDX_W-1:0] index;
        logic [7:0]       hi;
        logic [7:0]       dout;
        logic             ack;
    } seq_t;

    function automatic logic idx_valid(input logic [IDX_W-1:0] i);
        return (i <= IDX_LAST_LOW) || (i == IDX_HIGH);
    endfunction

    function automatic logic [4:0] idx_slot(input logic [IDX_W-1:0] i);
        return (i == IDX_HIGH) ? SLOT_HIGH : i[4:0];
    endfunction
endpackage

// File: rtl/dts_regbank.sv
module dts_regbank
    import dts_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              inc,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata,
    output logic [AW-1:0]     addr,
    output logic [CTRL_W-1:0] ctrl
);
    logic [WORD_W-1:0] regs_q [N_SLOTS];
    logic [WORD_W-1:0] regs_d [N_SLOTS];

    always_comb begin
        regs_d = regs_q;
        if (inc)
            regs_d[SLOT_ADDR] = regs_q[SLOT_ADDR] + 16'd1;
        if (we && idx_valid(widx)) begin
            if (widx == IDX_CTRL)
                regs_d[SLOT_CTRL] = {{(WORD_W-CTRL_W){1'b0}}, wdata[CTRL_W-1:0]};
            else
                regs_d[idx_slot(widx)] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = idx_valid(ridx) ? regs_q[idx_slot(ridx)] : '0;
    assign addr  = regs_q[SLOT_ADDR][AW-1:0];
    assign ctrl  = regs_q[SLOT_CTRL][CTRL_W-1:0];

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !we |=> regs_q[SLOT_ADDR] == $past(regs_q[SLOT_ADDR]) + 16'd1);

    // R5
    bad_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && !idx_valid(widx) && !inc |=> $stable(addr) && $stable(ctrl));

    // R6
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we && widx == IDX_CTRL |=> ctrl == $past(wdata[CTRL_W-1:0]));
endmodule

// File: rtl/dts_table_ram.sv
module dts_table_ram
    import dts_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    assign rdata = mem_q[addr];
endmodule

// File: rtl/disp_index_slave.sv
module disp_index_slave
    import dts_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              strobe,
    input  logic              rd,
    input  logic [2:0]        sel,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              ack,
    output logic [CTRL_W-1:0] ctrl
);
    seq_t s_q, s_d;

    logic              hit;
    logic              reg_we, ram_we, addr_inc;
    logic [WORD_W-1:0] wword, reg_rdata, ram_rdata;
    logic [RAM_AW-1:0] ram_addr;

    assign hit   = cs && strobe;
    assign wword = {s_q.hi, din};

    always_comb begin
        s_d      = s_q;
        reg_we   = 1'b0;
        ram_we   = 1'b0;
        addr_inc = 1'b0;
        s_d.ack  = hit;
        if (!cs) begin
            s_d.cnt = 2'd0;
        end else if (hit) begin
            if (s_q.cnt != 2'd3) s_d.cnt = s_q.cnt + 2'd1;
            s_d.dout = '0;
            case (sel)
                SEL_INDEX: begin
                    if (rd) begin
                        if (s_q.cnt == 2'd0) s_d.dout = s_q.index;
                    end else begin
                        case (s_q.cnt)
                            2'd0:    s_d.index = din;
                            2'd1:    s_d.hi    = din;
                            2'd2:    reg_we    = 1'b1;
                            default: ;
                        endcase
                    end
                end
                SEL_REGDATA: begin
                    if (rd) begin
                        if (s_q.cnt == 2'd0) s_d.dout = reg_rdata[15:8];
                        if (s_q.cnt == 2'd1) s_d.dout = reg_rdata[7:0];
                    end else begin
                        if (s_q.cnt == 2'd0) s_d.hi = din;
                        if (s_q.cnt == 2'd1) reg_we = 1'b1;
                    end
                end
                SEL_RAMDATA: begin
                    if (rd) begin
                        if (s_q.cnt == 2'd0) s_d.dout = ram_rdata[15:8];
                        if (s_q.cnt == 2'd1) begin
                            s_d.dout = ram_rdata[7:0];
                            addr_inc = 1'b1;
                        end
                    end else begin
                        if (s_q.cnt == 2'd0) s_d.hi = din;
                        if (s_q.cnt == 2'd1) begin
                            ram_we   = 1'b1;
                            addr_inc = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dts_regbank #(.AW(RAM_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .widx  (s_q.index),
        .wdata (wword),
        .inc   (addr_inc),
        .ridx  (s_q.index),
        .rdata (reg_rdata),
        .addr  (ram_addr),
        .ctrl  (ctrl)
    );

    dts_table_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (wword),
        .rdata (ram_rdata)
    );

    assign dout = s_q.dout;
    assign ack  = s_q.ack;

    // R1
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ack);

    // R1
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !ack);

    // R9
    dead_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit && sel != SEL_INDEX && sel != SEL_REGDATA && sel != SEL_RAMDATA
        |=> dout == 8'h00 && $stable(ctrl));
endmodule

// File: tb/disp_index_slave_test.sv
`timescale 1ns/1ps
module disp_index_slave_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, strobe = 1'b0, rd = 1'b0;
    logic [2:0] sel = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic ack;
    logic [10:0] ctrl;

    int tests = 0, fails = 0;
    int mreg [256];
    int mram [2048];
    int midx = 0;
    logic [7:0] got;
    logic mon_h;
    bit started = 0;

    always #2 clk = ~clk;

    disp_index_slave uut (.clk(clk), .rst_n(rst_n), .cs(cs), .strobe(strobe), .rd(rd),
                          .sel(sel), .din(din), .dout(dout), .ack(ack), .ctrl(ctrl));

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit mvalid(input int i);
        return (i <= 16) || (i == 32);
    endfunction

    function automatic int m_read(input int i);
        return mvalid(i) ? mreg[i] : 0;
    endfunction

    task automatic m_write(input int i, input int v);
        if (mvalid(i)) mreg[i] = (i == 16) ? (v & 16'h07FF) : (v & 16'hFFFF);
    endtask

    // per-clock comparison of acknowledge and control bits
    always @(posedge clk) begin
        mon_h = cs && strobe;
        #1;
        if (started) begin
            chk("R1 ack", int'(ack), int'(mon_h));
            chk("R6 ctrl", int'(ctrl), mreg[16]);
        end
    end

    task automatic put(input logic [2:0] s, input logic r, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; strobe = 1'b1; sel = s; rd = r; din = d;
        @(posedge clk); #1;
        got = dout;
        strobe = 1'b0;
    endtask

    task automatic close();
        @(negedge clk); cs = 1'b0; rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_reg3(input int i, input int v);
        put(3'd0, 1'b0, 8'(i)); midx = i;
        put(3'd0, 1'b0, 8'(v >> 8));
        m_write(i, v);
        put(3'd0, 1'b0, 8'(v));
        close();
    endtask

    task automatic set_idx(input int i);
        put(3'd0, 1'b0, 8'(i)); midx = i;
        close();
    endtask

    task automatic rd_reg(input string tag);
        int e;
        e = m_read(midx);
        put(3'd1, 1'b1, 8'h00); chk(tag, got, (e >> 8) & 255);
        put(3'd1, 1'b1, 8'h00); chk(tag, got, e & 255);
        close();
    endtask

    task automatic wr_reg(input int v);
        put(3'd1, 1'b0, 8'(v >> 8));
        m_write(midx, v);
        put(3'd1, 1'b0, 8'(v));
        close();
    endtask

    task automatic ram_wr(input int v);
        int a;
        a = mreg[7];
        put(3'd3, 1'b0, 8'(v >> 8));
        mram[a % 2048] = v & 16'hFFFF;
        mreg[7] = (a + 1) & 16'hFFFF;
        put(3'd3, 1'b0, 8'(v));
        close();
    endtask

    task automatic ram_rd(input string tag);
        int a, e;
        a = mreg[7];
        e = mram[a % 2048];
        put(3'd3, 1'b1, 8'h00); chk(tag, got, (e >> 8) & 255);
        mreg[7] = (a + 1) & 16'hFFFF;
        put(3'd3, 1'b1, 8'h00); chk(tag, got, e & 255);
        close();
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        foreach (mreg[i]) mreg[i] = 0;
        foreach (mram[i]) mram[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ack", int'(ack), 0);
        chk("R10 dout", int'(dout), 0);
        chk("R10 ctrl", int'(ctrl), 0);
        started = 1;
        set_idx(7);       rd_reg("R10 addr reg");
        set_idx(8'h20);   rd_reg("R10 high reg");

        // R2 / R6: three-byte write to the control register
        set_reg3(8'h10, 16'hFFFF);
        chk("R6 ctrl all", int'(ctrl), 16'h07FF);
        rd_reg("R6 upper bits zero");
        set_reg3(8'h10, 16'h0402);
        chk("R6 genlock select bit10", int'(ctrl[10]), 1);
        chk("R6 display enable bit1", int'(ctrl[1]), 1);
        chk("R6 vint bit0", int'(ctrl[0]), 0);

        // R2: extra fourth byte ignored
        put(3'd0, 1'b0, 8'h03); midx = 3;
        put(3'd0, 1'b0, 8'hBE);
        m_write(3, 16'hBEEF);
        put(3'd0, 1'b0, 8'hEF);
        put(3'd0, 1'b0, 8'h55);
        close();
        set_reg3(8'h05, 16'h1234);

        // R3: index only, then read on the data port
        set_idx(3);
        rd_reg("R3 read idx3");
        put(3'd0, 1'b1, 8'h00); chk("R3 index echo", got, 3); close();
        set_idx(5);
        rd_reg("R3 read idx5");

        // R4: data-port writes
        set_idx(8'h20); wr_reg(16'hA55A); rd_reg("R4 idx20");
        set_idx(8'h0F); wr_reg(16'h0F0F); rd_reg("R4 idx0F");
        set_idx(8'h00); wr_reg(16'h8001); rd_reg("R4 idx00");

        // R5: holes in the index space
        set_reg3(8'h11, 16'hDEAD); rd_reg("R5 idx11");
        set_idx(8'h1F); wr_reg(16'hFFFF); rd_reg("R5 idx1F");
        set_idx(8'h21); wr_reg(16'hFFFF); rd_reg("R5 idx21");
        set_idx(8'hFF); wr_reg(16'h1234); rd_reg("R5 idxFF");
        set_idx(8'h10); rd_reg("R5 ctrl untouched");

        // R7: memory port across the line/frame boundary
        set_reg3(7, 16'h03FF);
        ram_wr(16'h1357); ram_wr(16'h2468); ram_wr(16'hC0DE);
        set_idx(7); rd_reg("R7 addr after three words");
        set_reg3(7, 16'h03FF);
        ram_rd("R7 word 3FF"); ram_rd("R7 word 400"); ram_rd("R7 word 401");
        set_idx(7); rd_reg("R7 addr after reads");

        // R8: glyph region and address wrap
        set_reg3(7, 16'h0500); ram_wr(16'h7E81);
        set_reg3(7, 16'h07FF); ram_wr(16'h1111); ram_wr(16'h2222);
        set_idx(7); rd_reg("R8 addr reg counts past depth");
        set_reg3(7, 16'h0000); ram_rd("R8 word 0 via wrap");
        set_reg3(7, 16'h0500); ram_rd("R8 glyph word");
        set_reg3(7, 16'h0800); ram_rd("R8 alias of word 0");

        // R9: unused select codes
        set_idx(5);
        put(3'd2, 1'b1, 8'h00); chk("R9 sel2 read", got, 0);
        put(3'd4, 1'b0, 8'hAA); chk("R9 sel4 write", got, 0);
        put(3'd7, 1'b0, 8'hAA);
        close();
        put(3'd6, 1'b0, 8'h10); put(3'd6, 1'b0, 8'hFF); put(3'd6, 1'b0, 8'hFF); close();
        rd_reg("R9 idx5 unchanged");
        set_idx(8'h10); rd_reg("R9 ctrl unchanged");

        started = 0;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule